// File: doc/BRIEF.md
# Multiplexed ADC conversion sequencer

This block holds the control logic that sits between a microprocessor bus and a 16-channel sampling converter. The host lowers chip select and pulses the write strobe. When address-enable is high, the falling edge of write loads a new channel number and starts a settling interval for the analog path. When address-enable is low, the channel stays as it was and the settling interval is skipped. A conversion starts on whichever comes later: the rising edge of write or the end of settling. The sequencer sends the converter core a one-cycle start strobe. The conversion-status flag then stays high until the core returns its one-cycle done pulse together with a 12-bit result.

The result is held in a register and driven onto a 12-bit bus. A separate enable marks when the bus is driven and when it is high-impedance. A read cannot turn the bus on while a conversion is in flight. A read that was already active when the conversion began keeps showing the old value and switches to the new one in the cycle the status flag drops. Bus strobes are asynchronous and pass through two-stage synchronisers. Edges are detected in the system clock domain.

The state machine has five states. `SQ_IDLE` waits for a command. `SQ_SETTLE` counts the settling interval while write is still low. `SQ_SETTLE_ARMED` counts the settling interval after write has already risen. `SQ_AWAIT_WR` means settling is over and the sequencer waits for write to rise. `SQ_CONVERT` waits for the core's done pulse. The transitions are:
- IDLE→SETTLE on a write fall with address-enable high.
- IDLE→CONVERT on a write rise.
- SETTLE→SETTLE_ARMED on a write rise while counting.
- SETTLE→AWAIT_WR when the count expires.
- SETTLE or SETTLE_ARMED→CONVERT when the count expires with the write rise already seen.
- AWAIT_WR→CONVERT on a write rise.
- CONVERT→IDLE on done.

Every write edge here means one seen while chip select is low.

Top module: `adcseq_top`

## Requirements
- R1: With chip select low and address-enable high, a write falling edge loads `addr` into `chan_sel` and holds `settling` high for exactly SETTLE_CYCLES clock cycles.
- R2: If write rises while `settling` is high, `conv_start` fires in the cycle right after `settling` falls, and not before.
- R3: If write rises after settling has ended, `conv_start` fires in response to that rising edge.
- R4: With address-enable low, a write leaves `chan_sel` unchanged, `settling` never rises, and the write rising edge starts a conversion.
- R5: `conv_start` is high for one cycle. `busy` is high from that cycle until the cycle after the core's `core_done`, and then falls.
- R6: A write fall or rise seen while `settling` or `busy` is high has no effect: no extra start and no channel change.
- R7: `bus_oe` is low whenever `cs_n` or `rd_n` is high. `bus_oe` never goes from low to high while `busy` is high.
- R8: `bus_data` holds the previous result throughout a conversion and takes the new `core_result` in the cycle `busy` falls.
- R9: After reset, `chan_sel` is 0, `settling`, `busy`, `conv_start` and `bus_oe` are low, and `bus_data` is 0.
- R10: `cs_n`, `wr_n` and `rd_n` pass through two synchronising flip-flops. A write edge driven before clock edge k takes effect at edge k+2.
- R11: A write pulse with `cs_n` high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| aden | input | 1 | Address-enable: 1 reloads the channel and settles |
| addr | input | CH_W | Channel number to load |
| core_done | input | 1 | One-cycle done pulse from the converter core |
| core_result | input | DATA_W | Result valid with `core_done` |
| chan_sel | output | CH_W | Latched channel select to the analog mux |
| settling | output | 1 | High during the settling interval |
| busy | output | 1 | Conversion-status flag |
| conv_start | output | 1 | One-cycle start strobe to the converter core |
| bus_oe | output | 1 | Result bus drive enable (0 = high-impedance) |
| bus_data | output | DATA_W | Held result |

## Verification
The bench builds the block with SETTLE_CYCLES = 8 instead of the several hundred cycles of the default. The converter core model answers 12 cycles after each start. With these values, a write rise lands a few cycles before, at, or after the end of settling. Commands can also be aimed into the settling window and the busy window within one short run. A behavioural reference model predicts every output on every clock, and directed checks confirm channel retention, start counts and strobe latency.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_SETTLE_ARMED,
        SQ_AWAIT_WR,
        SQ_CONVERT
    } seq_state_t;
endpackage

// File: rtl/adcseq_sync.sv
// Two-stage synchroniser bank for asynchronous strobes.
module adcseq_sync #(
    parameter int WIDTH   = 3,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                sync_q <= RST_VAL;
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign q_sync[i] = sync_q;
    end
endmodule

// File: rtl/adcseq_fsm.sv
// Channel-select / settle / convert sequencing.
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int CH_W          = 4,
    parameter int SETTLE_CYCLES = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_act,
    input  logic            wr_s,
    input  logic            aden,
    input  logic [CH_W-1:0] addr,
    input  logic            core_done,
    output logic [CH_W-1:0] chan_sel,
    output logic            settling,
    output logic            busy,
    output logic            conv_start
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CH_W-1:0]  chan_q, chan_d;
    logic             start_q, start_d;
    logic             wr_prev_q;
    logic             wr_fall, wr_rise, armed;

    assign wr_fall = cs_act &  wr_prev_q & ~wr_s;
    assign wr_rise = cs_act & ~wr_prev_q &  wr_s;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        chan_d  = chan_q;
        start_d = 1'b0;
        armed   = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (wr_fall && aden) begin
                    state_d = SQ_SETTLE;
                    cnt_d   = CNT_LOAD;
                    chan_d  = addr;
                end else if (wr_rise) begin
                    state_d = SQ_CONVERT;
                    start_d = 1'b1;
                end
            end
            SQ_SETTLE, SQ_SETTLE_ARMED: begin
                armed = (state_q == SQ_SETTLE_ARMED) || wr_rise;
                if (cnt_q == '0) begin
                    if (armed) begin
                        state_d = SQ_CONVERT;
                        start_d = 1'b1;
                    end else begin
                        state_d = SQ_AWAIT_WR;
                    end
                end else begin
                    cnt_d   = cnt_q - 1'b1;
                    state_d = armed ? SQ_SETTLE_ARMED : SQ_SETTLE;
                end
            end
            SQ_AWAIT_WR: begin
                if (wr_rise) begin
                    state_d = SQ_CONVERT;
                    start_d = 1'b1;
                end
            end
            SQ_CONVERT: begin
                if (core_done) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            cnt_q     <= '0;
            chan_q    <= '0;
            start_q   <= 1'b0;
            wr_prev_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            chan_q    <= chan_d;
            start_q   <= start_d;
            wr_prev_q <= wr_s;
        end
    end

    always_comb begin
        chan_sel   = chan_q;
        settling   = (state_q == SQ_SETTLE) || (state_q == SQ_SETTLE_ARMED);
        busy       = (state_q == SQ_CONVERT);
        conv_start = start_q;
    end

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r5_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(settling && busy));
    a_r4_chan_moves_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != $past(chan_sel)) |-> settling);
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_done) |=> (busy && !settling));
endmodule

// File: rtl/adcseq_bus.sv
// Result register and bus drive enable.
module adcseq_bus #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              busy,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_result,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);
    logic              oe_q;
    logic [DATA_W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            res_q <= '0;
        end else begin
            oe_q <= ~cs_s & ~rd_s & (oe_q | ~busy);
            if (busy && core_done) res_q <= core_result;
        end
    end

    assign bus_oe   = oe_q;
    assign bus_data = res_q;

    a_r7_no_enable_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !$past(bus_oe)) |-> !$past(busy));
    a_r8_data_held_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_done) |=> $stable(bus_data));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
    parameter int CH_W          = 4,
    parameter int DATA_W        = 12,
    parameter int SETTLE_CYCLES = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              aden,
    input  logic [CH_W-1:0]   addr,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_result,
    output logic [CH_W-1:0]   chan_sel,
    output logic              settling,
    output logic              busy,
    output logic              conv_start,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);
    logic [2:0] strb_s;

    adcseq_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({rd_n, wr_n, cs_n}),
        .q_sync  (strb_s)
    );

    adcseq_fsm #(.CH_W(CH_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (~strb_s[0]),
        .wr_s       (strb_s[1]),
        .aden       (aden),
        .addr       (addr),
        .core_done  (core_done),
        .chan_sel   (chan_sel),
        .settling   (settling),
        .busy       (busy),
        .conv_start (conv_start)
    );

    adcseq_bus #(.DATA_W(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (strb_s[0]),
        .rd_s        (strb_s[2]),
        .busy        (busy),
        .core_done   (core_done),
        .core_result (core_result),
        .bus_oe      (bus_oe),
        .bus_data    (bus_data)
    );
endmodule

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int CH_W        = 4;
    localparam int DATA_W      = 12;
    localparam int SETTLE      = 8;
    localparam int CONV_CYCLES = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, aden = 1'b0;
    logic [CH_W-1:0] addr = '0;
    logic core_done = 1'b0;
    logic [DATA_W-1:0] core_result = '0;
    logic [CH_W-1:0] chan_sel;
    logic settling, busy, conv_start, bus_oe;
    logic [DATA_W-1:0] bus_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcseq_top #(.CH_W(CH_W), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .aden(aden), .addr(addr), .core_done(core_done), .core_result(core_result),
        .chan_sel(chan_sel), .settling(settling), .busy(busy),
        .conv_start(conv_start), .bus_oe(bus_oe), .bus_data(bus_data)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Converter core model: answers CONV_CYCLES after each start.
    int cdn = 0;
    int nconv = 0;
    always @(negedge clk) begin
        core_done = 1'b0;
        if (!rst_n) cdn = 0;
        else if (conv_start) begin
            cdn = CONV_CYCLES;
            nconv++;
        end else if (cdn > 0) begin
            cdn--;
            if (cdn == 0) begin
                core_done   = 1'b1;
                core_result = DATA_W'(nconv * 291 + int'(chan_sel) * 17 + 3);
            end
        end
    end

    // Behavioural reference model, stepped on every clock.
    int m_state, m_cnt, m_chan, m_res;
    bit m_start, m_oe;
    bit c1, cs2, w1, ws2, wprev, r1, rs2;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_chan = 0; m_res = 0; m_start = 0; m_oe = 0;
            c1 = 1; cs2 = 1; w1 = 1; ws2 = 1; wprev = 1; r1 = 1; rs2 = 1;
        end else begin
            bit fall, rise, arm, was_busy;
            int nxt;
            fall = !cs2 && wprev && !ws2;
            rise = !cs2 && !wprev && ws2;
            was_busy = (m_state == 4);
            nxt = m_state;
            case (m_state)
                0: if (fall && aden) begin nxt = 1; m_cnt = SETTLE - 1; m_chan = int'(addr); end
                   else if (rise) nxt = 4;
                1, 2: begin
                    arm = (m_state == 2) || rise;
                    if (m_cnt == 0) nxt = arm ? 4 : 3;
                    else begin m_cnt--; nxt = arm ? 2 : 1; end
                end
                3: if (rise) nxt = 4;
                default: if (core_done) begin nxt = 0; m_res = int'(core_result); end
            endcase
            m_start = (nxt == 4) && (m_state != 4);
            m_oe = !cs2 && !rs2 && (m_oe || !was_busy);
            m_state = nxt;
            wprev = ws2; ws2 = w1; w1 = wr_n;
            cs2 = c1; c1 = cs_n;
            rs2 = r1; r1 = rd_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(chan_sel) == m_chan, "R1", "chan_sel", int'(chan_sel), m_chan);
            chk(settling == (m_state == 1 || m_state == 2), "R2", "settling",
                int'(settling), int'(m_state == 1 || m_state == 2));
            chk(busy == (m_state == 4), "R5", "busy", int'(busy), int'(m_state == 4));
            chk(conv_start == m_start, "R3", "conv_start", int'(conv_start), int'(m_start));
            chk(bus_oe == m_oe, "R7", "bus_oe", int'(bus_oe), int'(m_oe));
            chk(int'(bus_data) == m_res, "R8", "bus_data", int'(bus_data), m_res);
        end
    end

    task automatic do_write(input bit en, input int ch, input int hold);
        aden = en;
        addr = CH_W'(ch);
        wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy && !settling && wr_n && i > 4) break;
        end
        repeat (3) @(negedge clk);
    endtask

    int exp_starts = 0;
    bit saw_settle;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(chan_sel == '0, "R9", "chan_sel", int'(chan_sel), 0);
        chk(!settling && !busy && !conv_start, "R9", "flags",
            int'({settling, busy, conv_start}), 0);
        chk(!bus_oe && bus_data == '0, "R9", "bus", int'(bus_oe) + int'(bus_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);

        // R10 latency + R2: write rises during settling
        aden = 1'b1; addr = 4'd5; wr_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(!settling, "R10", "settling after two edges", int'(settling), 0);
        @(posedge clk); @(negedge clk);
        chk(settling, "R10", "settling after three edges", int'(settling), 1);
        wr_n = 1'b1;
        exp_starts++;
        wait_quiet();
        chk(int'(chan_sel) == 5, "R1", "channel loaded", int'(chan_sel), 5);

        // R7: read after conversion enables bus
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(bus_oe, "R7", "bus on after read", int'(bus_oe), 1);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!bus_oe, "R7", "bus off after read high", int'(bus_oe), 0);

        // R3: write held past the end of settling
        do_write(1'b1, 9, SETTLE + 10);
        exp_starts++;
        wait_quiet();

        // R4: address-enable low keeps channel, no settling
        saw_settle = 1'b0;
        aden = 1'b0; addr = 4'd3; wr_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (settling) saw_settle = 1'b1;
            if (i == 3) wr_n = 1'b1;
        end
        exp_starts++;
        chk(!saw_settle, "R4", "settling seen", int'(saw_settle), 0);
        chk(int'(chan_sel) == 9, "R4", "channel kept", int'(chan_sel), 9);
        wait_quiet();

        // R8: read held across a conversion
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        do_write(1'b1, 12, 2);
        exp_starts++;
        wait_quiet();
        chk(bus_oe && bus_data == core_result, "R8", "new result on bus",
            int'(bus_data), int'(core_result));
        rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: commands during settling and busy are ignored
        do_write(1'b1, 2, 2);
        exp_starts++;
        @(negedge clk);
        do_write(1'b1, 6, 2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy) break;
        end
        do_write(1'b1, 7, 2);
        wait_quiet();
        chk(int'(chan_sel) == 2, "R6", "channel after ignored writes", int'(chan_sel), 2);
        chk(nconv == exp_starts, "R6", "start count", nconv, exp_starts);

        // R11: write with chip select high
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        do_write(1'b1, 11, 3);
        repeat (20) @(negedge clk);
        chk(!settling && !busy && int'(chan_sel) == 2, "R11", "cs high write",
            int'(chan_sel), 2);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);

        // R7: read starting during busy does not drive the bus
        do_write(1'b0, 0, 2);
        exp_starts++;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) break;
        end
        rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(!bus_oe, "R7", "bus during busy", int'(bus_oe), 0);
        wait_quiet();
        chk(bus_oe, "R7", "bus after busy", int'(bus_oe), 1);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(nconv == exp_starts, "R5", "final start count", nconv, exp_starts);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule